// File: doc/BRIEF.md
# RMII to MII PHY-side adapter

This block sits inside a PHY, between a reduced media independent interface facing the MAC and the PHY's own nibble-wide MII. Every register runs on one 50 MHz reference clock. In the transmit direction it collects pairs of 2-bit dibits into 4-bit nibbles. It hands each nibble to the PHY core together with a one-cycle nibble strobe. That strobe is a clock enable held in fixed phase with the reference clock, so the transmit direction needs no elasticity buffer. In the receive direction the block pulls one nibble at a time from the PHY core and sends it back out as two dibits. It also forms the combined carrier/data-valid signal and the receive error.

A speed input selects the mode. At 100 Mb/s each dibit lasts one reference cycle. At 10 Mb/s each dibit lasts `SLOW_DIV` reference cycles. The transmit timing in slow mode is re-aligned whenever transmit enable rises, so each dibit is sampled once, in the middle of its window. The block drives the core's transmit error low. It forms the collision signal from carrier and transmit enable when the link is half duplex.

Top module: `rmii_mii_bridge`

## Requirements
- R1: While reset is applied, `mii_tx_en`, `mii_txd`, `mii_tx_stb`, `rmii_rxd`, `rmii_crs_dv` and `rmii_rx_er` are all 0.
- R2: Within a frame, the dibit sampled first forms `mii_txd[1:0]` and the one sampled second forms `mii_txd[3:2]`. Each complete nibble appears with `mii_tx_en` high, in the same cycle as a `mii_tx_stb` pulse. Every nibble the MAC sends is delivered, in order.
- R3: Values on `rmii_txd` while `rmii_tx_en` is low have no effect. Within one dibit period after the enable falls, `mii_tx_en` is 0 and `mii_txd` is 0, and both stay there until the next frame.
- R4: `mii_tx_stb` is never high in two consecutive cycles. Inside a frame, consecutive nibble strobes are exactly two dibit periods apart (2 cycles when fast, 2*`SLOW_DIV` when slow).
- R5: When `speed_fast`=0, a transmit dibit window is `SLOW_DIV` cycles long. The first window starts in the cycle where `rmii_tx_en` rises. The dibit is sampled only at cycle index `SLOW_DIV`/2 of each window, counting from 0.
- R6: The receive nibble captured on a `mii_rx_stb` edge goes out as bits [1:0] for one dibit period, starting the next cycle, and then as bits [3:2] for one dibit period. `rmii_rxd` is 00 for a nibble whose `mii_rx_dv` was low.
- R7: `rmii_crs_dv` equals the captured `mii_crs` during a nibble's first dibit and equals `mii_crs` OR `mii_rx_dv` during its second dibit. As a result, after carrier drops it alternates once per dibit while data drains.
- R8: `rmii_rx_er` equals the captured `mii_rx_er` for both dibits of that nibble.
- R9: `mii_rx_stb` marks the edge at which the receive nibble inputs are taken. It is never high in two consecutive cycles, and it pulses exactly every two dibit periods.
- R10: `mii_tx_er` is always 0. `mii_col` equals NOT `full_duplex` AND `mii_crs` AND `mii_tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| speed_fast | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex (collision suppressed) |
| rmii_tx_en | input | 1 | Transmit enable from the MAC |
| rmii_txd | input | 2 | Transmit dibit from the MAC |
| rmii_rxd | output | 2 | Receive dibit to the MAC |
| rmii_crs_dv | output | 1 | Combined carrier sense / data valid to the MAC |
| rmii_rx_er | output | 1 | Receive error to the MAC |
| mii_tx_stb | output | 1 | Transmit nibble clock enable to the PHY core |
| mii_tx_en | output | 1 | Transmit enable to the PHY core |
| mii_txd | output | 4 | Transmit nibble to the PHY core |
| mii_tx_er | output | 1 | Transmit error to the PHY core (held low) |
| mii_col | output | 1 | Collision indication |
| mii_rx_stb | output | 1 | Receive nibble take strobe to the PHY core |
| mii_crs | input | 1 | Carrier sense from the PHY core |
| mii_rx_dv | input | 1 | Receive data valid from the PHY core |
| mii_rxd | input | 4 | Receive nibble from the PHY core |
| mii_rx_er | input | 1 | Receive error from the PHY core |

## Verification
The bench builds the adapter with `SLOW_DIV`=6 instead of 10. This keeps 10 Mb/s frames short enough to run several of them in both directions. Because 6 is even, the mid-window sampling point falls at index 3. In slow mode the bench drives the inverted dibit on every cycle of each window except that index, so any shift of the sampling point, or a failure to re-align on a rising enable, corrupts the delivered nibbles. Half and full duplex are mixed per frame, so collision is exercised against random receive carrier.

// File: rtl/rmii_pkg.sv
package rmii_pkg;
  localparam int DIBIT_W = 2;
  localparam int NIB_W   = 2 * DIBIT_W;

  typedef logic [DIBIT_W-1:0] dibit_t;
  typedef logic [NIB_W-1:0]   nibble_t;

  // receive nibble as taken from the PHY core
  typedef struct packed {
    logic    crs;
    logic    dv;
    logic    er;
    nibble_t data;
  } rx_nib_t;
endpackage

// File: rtl/rmii_rst_sync.sv
module rmii_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/rmii_tick_gen.sv
// Dibit-rate tick: every cycle when fast, once per DIV cycles when slow.
module rmii_tick_gen #(
  parameter int DIV       = 10,
  parameter int SAMPLE_AT = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HIT  = CW'(SAMPLE_AT);

  logic [CW-1:0] cnt_q, cnt_d, cnt_eff;
  logic          cnt_en;

  always_comb begin
    cnt_en  = ~fast;
    cnt_eff = restart ? '0 : cnt_q;
    if (cnt_eff == LAST) cnt_d = '0;
    else                 cnt_d = cnt_eff + 1'b1;
    tick    = fast | (cnt_eff == HIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rmii_tx_pack.sv
module rmii_tx_pack
  import rmii_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    start,
  input  logic    tx_en,
  input  dibit_t  txd,
  output logic    nib_en,
  output nibble_t nib,
  output logic    nib_stb
);
  logic    phase_q, phase_d, phase_eff;
  dibit_t  lo_q, lo_d;
  logic    en_q, en_d;
  nibble_t nib_q, nib_d;
  logic    stb_q, stb_d;

  always_comb begin
    phase_eff = start ? 1'b0 : phase_q;
    phase_d   = start ? 1'b0 : phase_q;
    lo_d      = lo_q;
    en_d      = en_q;
    nib_d     = nib_q;
    stb_d     = 1'b0;
    if (tick) begin
      phase_d = ~phase_eff;
      stb_d   = phase_eff;
      if (!tx_en) begin
        en_d  = 1'b0;
        nib_d = '0;
      end else if (!phase_eff) begin
        lo_d  = txd;
      end else begin
        nib_d = {txd, lo_q};
        en_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lo_q    <= '0;
      en_q    <= 1'b0;
      nib_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      lo_q    <= lo_d;
      en_q    <= en_d;
      nib_q   <= nib_d;
      stb_q   <= stb_d;
    end
  end

  assign nib_en  = en_q;
  assign nib     = nib_q;
  assign nib_stb = stb_q;
endmodule

// File: rtl/rmii_rx_split.sv
module rmii_rx_split
  import rmii_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  rx_nib_t nib_in,
  output logic    take,
  output dibit_t  rxd,
  output logic    crs_dv,
  output logic    rx_er
);
  logic    phase_q, phase_d;
  rx_nib_t cap_q, cap_d;
  dibit_t  rxd_q, rxd_d;
  logic    cdv_q, cdv_d;
  logic    er_q, er_d;

  always_comb begin
    take    = tick & ~phase_q;
    phase_d = tick ? ~phase_q : phase_q;
    cap_d   = cap_q;
    rxd_d   = rxd_q;
    cdv_d   = cdv_q;
    er_d    = er_q;
    if (take) begin
      cap_d = nib_in;
      rxd_d = nib_in.dv ? nib_in.data[DIBIT_W-1:0] : '0;
      cdv_d = nib_in.crs;
      er_d  = nib_in.er;
    end else if (tick) begin
      rxd_d = cap_q.dv ? cap_q.data[NIB_W-1:DIBIT_W] : '0;
      cdv_d = cap_q.crs | cap_q.dv;
      er_d  = cap_q.er;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cap_q   <= '0;
      rxd_q   <= '0;
      cdv_q   <= 1'b0;
      er_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cap_q   <= cap_d;
      rxd_q   <= rxd_d;
      cdv_q   <= cdv_d;
      er_q    <= er_d;
    end
  end

  assign rxd    = rxd_q;
  assign crs_dv = cdv_q;
  assign rx_er  = er_q;
endmodule

// File: rtl/rmii_mii_bridge.sv
module rmii_mii_bridge
  import rmii_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_fast,
  input  logic       full_duplex,
  input  logic       rmii_tx_en,
  input  logic [1:0] rmii_txd,
  output logic [1:0] rmii_rxd,
  output logic       rmii_crs_dv,
  output logic       rmii_rx_er,
  output logic       mii_tx_stb,
  output logic       mii_tx_en,
  output logic [3:0] mii_txd,
  output logic       mii_tx_er,
  output logic       mii_col,
  output logic       mii_rx_stb,
  input  logic       mii_crs,
  input  logic       mii_rx_dv,
  input  logic [3:0] mii_rxd,
  input  logic       mii_rx_er
);
  localparam int MID = SLOW_DIV / 2;

  logic    rst_core_n;
  logic    tx_en_d;
  logic    tx_start;
  logic    tx_tick, rx_tick;
  rx_nib_t rx_in;

  rmii_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) tx_en_d <= 1'b0;
    else             tx_en_d <= rmii_tx_en;
  end

  assign tx_start = rmii_tx_en & ~tx_en_d;

  rmii_tick_gen #(.DIV(SLOW_DIV), .SAMPLE_AT(MID)) u_tx_tick (
    .clk(clk), .rst_n(rst_core_n), .fast(speed_fast),
    .restart(tx_start), .tick(tx_tick)
  );

  rmii_tick_gen #(.DIV(SLOW_DIV), .SAMPLE_AT(0)) u_rx_tick (
    .clk(clk), .rst_n(rst_core_n), .fast(speed_fast),
    .restart(1'b0), .tick(rx_tick)
  );

  rmii_tx_pack u_tx (
    .clk(clk), .rst_n(rst_core_n), .tick(tx_tick), .start(tx_start),
    .tx_en(rmii_tx_en), .txd(rmii_txd),
    .nib_en(mii_tx_en), .nib(mii_txd), .nib_stb(mii_tx_stb)
  );

  always_comb begin
    rx_in.crs  = mii_crs;
    rx_in.dv   = mii_rx_dv;
    rx_in.er   = mii_rx_er;
    rx_in.data = mii_rxd;
  end

  rmii_rx_split u_rx (
    .clk(clk), .rst_n(rst_core_n), .tick(rx_tick), .nib_in(rx_in),
    .take(mii_rx_stb), .rxd(rmii_rxd), .crs_dv(rmii_crs_dv), .rx_er(rmii_rx_er)
  );

  assign mii_tx_er = 1'b0;
  assign mii_col   = ~full_duplex & mii_crs & mii_tx_en;
endmodule

// File: rtl/rmii_mii_bridge_chk.sv
module rmii_mii_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       full_duplex,
  input logic       mii_crs,
  input logic       mii_tx_en,
  input logic [3:0] mii_txd,
  input logic       mii_tx_stb,
  input logic       mii_rx_stb,
  input logic       mii_col
);
  // R4
  tx_stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mii_tx_stb |=> !mii_tx_stb);

  // R9
  rx_stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mii_rx_stb |=> !mii_rx_stb);

  // R2
  tx_en_rise_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_tx_en) |-> mii_tx_stb);

  // R3
  tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_tx_en |-> (mii_txd == 4'h0));

  // R10
  col_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mii_col |-> (mii_tx_en && mii_crs && !full_duplex));
endmodule

bind rmii_mii_bridge rmii_mii_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_core_n), .full_duplex(full_duplex), .mii_crs(mii_crs),
  .mii_tx_en(mii_tx_en), .mii_txd(mii_txd), .mii_tx_stb(mii_tx_stb),
  .mii_rx_stb(mii_rx_stb), .mii_col(mii_col)
);

// File: tb/rmii_mii_bridge_tb_top.sv
`timescale 1ns/100ps
module rmii_mii_bridge_tb_top;
  localparam int DIV = 6;

  logic       clk = 1'b0;
  logic       rst_n, speed_fast, full_duplex, rmii_tx_en;
  logic [1:0] rmii_txd, rmii_rxd;
  logic       rmii_crs_dv, rmii_rx_er, mii_tx_stb, mii_tx_en, mii_tx_er, mii_col, mii_rx_stb;
  logic [3:0] mii_txd, mii_rxd;
  logic       mii_crs, mii_rx_dv, mii_rx_er;

  rmii_mii_bridge #(.SLOW_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .speed_fast(speed_fast), .full_duplex(full_duplex),
    .rmii_tx_en(rmii_tx_en), .rmii_txd(rmii_txd), .rmii_rxd(rmii_rxd),
    .rmii_crs_dv(rmii_crs_dv), .rmii_rx_er(rmii_rx_er), .mii_tx_stb(mii_tx_stb),
    .mii_tx_en(mii_tx_en), .mii_txd(mii_txd), .mii_tx_er(mii_tx_er), .mii_col(mii_col),
    .mii_rx_stb(mii_rx_stb), .mii_crs(mii_crs), .mii_rx_dv(mii_rx_dv),
    .mii_rxd(mii_rxd), .mii_rx_er(mii_rx_er)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int len = 1;
  bit run = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // expected transmit nibbles
  logic [3:0] expq[$];
  int  tx_prev;
  bit  tx_have_prev;

  // transmit monitor: R2 content/order, R4 spacing
  always @(negedge clk) begin
    if (run && mii_tx_stb && mii_tx_en) begin
      if (expq.size() == 0) chk_eq("R2 unexpected nibble", 1, 0);
      else chk_eq("R2 nibble value", int'(mii_txd), int'(expq.pop_front()));
      if (tx_have_prev) chk_eq("R4 nibble strobe spacing", cyc - tx_prev, 2 * len);
      tx_prev = cyc;
      tx_have_prev = 1;
    end
  end

  // R10 collision and transmit error
  always @(negedge clk) begin
    if (run) begin
      #1;
      chk_eq("R10 col", int'(mii_col), int'(!full_duplex && mii_crs && mii_tx_en));
      chk_eq("R10 tx_er low", int'(mii_tx_er), 0);
    end
  end

  // PHY-core receive model and checks: R6, R7, R8, R9
  logic [3:0] t_d;
  logic t_crs, t_dv, t_er;
  bit took;
  int hi_cnt;
  int rx_prev;
  bit rx_have_prev;

  task automatic present_rx();
    int r = int'($urandom % 8);
    mii_rxd   = 4'($urandom);
    mii_crs   = (r >= 2 && r != 5);
    mii_rx_dv = (r >= 2 && r != 6);
    mii_rx_er = (r == 7) || (r == 3 && ($urandom % 2 == 0));
  endtask

  always @(negedge clk) begin
    if (!run) begin
      took = 0; hi_cnt = 0; rx_have_prev = 0;
    end else begin
      if (hi_cnt > 0) begin
        hi_cnt--;
        if (hi_cnt == 0) begin
          chk_eq("R6 rxd high dibit", int'(rmii_rxd), t_dv ? int'(t_d[3:2]) : 0);
          chk_eq("R7 crs_dv second dibit", int'(rmii_crs_dv), int'(t_crs | t_dv));
          chk_eq("R8 rx_er second dibit", int'(rmii_rx_er), int'(t_er));
        end
      end
      if (took) begin
        t_d = mii_rxd; t_crs = mii_crs; t_dv = mii_rx_dv; t_er = mii_rx_er;
        chk_eq("R6 rxd low dibit", int'(rmii_rxd), t_dv ? int'(t_d[1:0]) : 0);
        chk_eq("R7 crs_dv first dibit", int'(rmii_crs_dv), int'(t_crs));
        chk_eq("R8 rx_er first dibit", int'(rmii_rx_er), int'(t_er));
        hi_cnt = len;
        present_rx();
      end
      took = mii_rx_stb;
      if (took) begin
        if (rx_have_prev) chk_eq("R9 take strobe spacing", cyc - rx_prev, 2 * len);
        rx_prev = cyc;
        rx_have_prev = 1;
      end
    end
  end

  task automatic do_reset();
    run = 0;
    rst_n = 0;
    rmii_tx_en = 0;
    rmii_txd = 2'b11;
    present_rx();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 mii_tx_en", int'(mii_tx_en), 0);
    chk_eq("R1 mii_txd", int'(mii_txd), 0);
    chk_eq("R1 mii_tx_stb", int'(mii_tx_stb), 0);
    chk_eq("R1 rmii_rxd", int'(rmii_rxd), 0);
    chk_eq("R1 rmii_crs_dv", int'(rmii_crs_dv), 0);
    chk_eq("R1 rmii_rx_er", int'(rmii_rx_er), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    expq.delete();
    run = 1;
  endtask

  // one dibit window; in slow mode only index DIV/2 carries the true value (R5)
  task automatic drive_dibit(input logic [1:0] d);
    for (int i = 0; i < len; i++) begin
      rmii_tx_en = 1;
      rmii_txd = (len == 1 || i == DIV / 2) ? d : ~d;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input int nnib, input int gap);
    full_duplex = 1'($urandom);
    tx_have_prev = 0;
    for (int n = 0; n < nnib; n++) begin
      logic [1:0] d0 = 2'($urandom);
      logic [1:0] d1 = 2'($urandom);
      expq.push_back({d1, d0});
      drive_dibit(d0);
      drive_dibit(d1);
    end
    rmii_tx_en = 0;
    for (int i = 0; i < gap; i++) begin
      rmii_txd = 2'($urandom);
      @(negedge clk);
      if (i >= len + 2) begin
        // R3 idle dibits ignored
        chk_eq("R3 tx_en idle", int'(mii_tx_en), 0);
        chk_eq("R3 txd idle", int'(mii_txd), 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1D5EED));
    rst_n = 0; speed_fast = 1; full_duplex = 0; rmii_tx_en = 0; rmii_txd = 0;
    mii_crs = 0; mii_rx_dv = 0; mii_rxd = 0; mii_rx_er = 0;
    @(negedge clk);
    for (int sp = 1; sp >= 0; sp--) begin
      speed_fast = sp[0];
      len = sp ? 1 : DIV;
      do_reset();
      // directed: single-nibble frame, then a pattern with every dibit value
      send_frame(1, 3 * len + 4);
      send_frame(2, 2 * len + 4);
      for (int f = 0; f < (sp ? 10 : 4); f++)
        send_frame(2 + int'($urandom % 7), 2 * len + 4 + int'($urandom % 5));
      repeat (4 * len) @(negedge clk);
      chk_eq("R2 all nibbles delivered", expq.size(), 0);
    end
    run = 0;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule